// File: doc/BRIEF.md
# Four-Level Page Table Walker

This engine resolves a translation miss. It walks a radix page table of four levels held in memory. When a request is accepted, the engine latches the virtual page number, the page offset and the root table base. It then fetches one 64-bit entry per level and checks the present flag of each entry. It folds the permission flags of all four levels into one result and returns the physical page number, the full physical address and the merged permissions. If an entry on the path is not present, it reports a fault and the level where the walk stopped.

Each entry the walk visits is marked as accessed. When a fetched entry has its accessed flag clear, the engine writes that entry back to the same address with the flag set before it moves on. When the flag is already set, no write is issued. The engine has one memory port with a request/acknowledge handshake. At most one request is outstanding at any time.

Top module: `table_walker`

## Requirements
- R1: After reset the engine is idle. `busy`, `memReq` and `doneValid` are all low.
- R2: The level-k entry address is the table base, then the k-th 9-bit slice of the VPN, then three zero bits. The slices are taken from the most significant end down: VPN[35:27] indexes level 1 and VPN[8:0] indexes level 4. The level-1 base is `rootBase`. Each later base is bits 51:12 of the entry from the level above.
- R3: `memReq` stays high, and `memAddr`, `memWe` and `memWdata` stay unchanged, from the cycle it rises until the cycle `memAck` is sampled high. Only one request is ever open.
- R4: Bit 0 of an entry is the present flag. An entry with bit 0 clear ends the walk with `doneFault` high, `faultLevel` set to that level (1 to 4), no write-back of that entry and no further memory access.
- R5: Bit 5 is the accessed flag. A present entry with bit 5 clear is written back to its own address with bit 5 set and all other bits unchanged. A present entry with bit 5 already set causes no write.
- R6: `permWrite` is the AND of bit 1 over all four entries. `permUser` is the AND of bit 2 over all four entries. `execDisable` is the OR of bit 63 over all four entries.
- R7: On success, `ppn` is bits 51:12 of the level-4 entry, `physAddr` is `{ppn, offset}`, and `globalPage` is bit 8 of the level-4 entry.
- R8: Each accepted request produces exactly one single-cycle `doneValid` pulse, after which the engine is idle. A start request made while `busy` is high is ignored. Changes to `reqVpn`, `reqOffset` or `rootBase` during a walk do not affect its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start a walk (taken only when idle) |
| reqVpn | input | 36 | Virtual page number to translate |
| reqOffset | input | 12 | Page offset carried into the physical address |
| rootBase | input | 40 | Level-1 table base (4 KB frame number) |
| busy | output | 1 | A walk is in progress |
| memReq | output | 1 | Memory request open |
| memWe | output | 1 | Request is a write |
| memAddr | output | 52 | Byte address of the entry |
| memWdata | output | 64 | Write-back data |
| memAck | input | 1 | Request completes in this cycle |
| memRdata | input | 64 | Read data, valid with memAck on a read |
| doneValid | output | 1 | Result pulse |
| doneFault | output | 1 | Walk ended on a non-present entry |
| faultLevel | output | 3 | Level (1 to 4) of the non-present entry |
| ppn | output | 40 | Physical page number |
| physAddr | output | 52 | Physical address |
| permWrite | output | 1 | Merged write permission |
| permUser | output | 1 | Merged user permission |
| execDisable | output | 1 | Merged execute-disable |
| globalPage | output | 1 | Global flag of the final entry |

## Verification
Two things can coincide. One is the end of a walk, marked by the result pulse. The other is a new start request that was raised while that walk was still running. The bench raises a start with a different VPN partway through a slow walk and holds it for several cycles. It then checks two things. Only the first walk's result appears, computed from the VPN latched at acceptance. No second pulse follows in the cycles after it. A second coincidence is the permission merge and the accessed write-back, which act on the same entry. The bench judges this by comparing the merged flags against the count of write-backs seen on the memory port.

// File: rtl/walk_pkg.sv
package walk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_CHECK, ST_WRITE_A, ST_DONE, ST_FAULT
  } walkState_e;

  typedef struct packed {
    logic load;     // accept request, latch inputs
    logic capture;  // latch fetched entry
    logic merge;    // fold entry flags into permissions
    logic advance;  // step to next level (or finish)
  } walkStrobe_t;

  localparam int ENTRY_W    = 64;
  localparam int BIT_PRESENT = 0;
  localparam int BIT_WRITE   = 1;
  localparam int BIT_USER    = 2;
  localparam int BIT_ACCESS  = 5;
  localparam int BIT_GLOBAL  = 8;
  localparam int BIT_NOEXEC  = 63;
endpackage

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startValid,
  input  logic        memAck,
  input  logic        entryPresent,
  input  logic        entryAccessed,
  input  logic        lastLevel,
  output walkStrobe_t strb,
  output logic        memReq,
  output logic        memWe,
  output logic        busy,
  output logic        doneValid,
  output logic        doneFault
);
  walkState_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:    if (startValid) stateD = ST_READ;
      ST_READ:    if (memAck) stateD = ST_CHECK;
      ST_CHECK: begin
        if (!entryPresent)       stateD = ST_FAULT;
        else if (!entryAccessed) stateD = ST_WRITE_A;
        else if (lastLevel)      stateD = ST_DONE;
        else                     stateD = ST_READ;
      end
      ST_WRITE_A: if (memAck) stateD = lastLevel ? ST_DONE : ST_READ;
      ST_DONE:    stateD = ST_IDLE;
      ST_FAULT:   stateD = ST_IDLE;
      default:    stateD = ST_IDLE;
    endcase
  end

  always_comb begin
    strb.load    = (stateQ == ST_IDLE) && startValid;
    strb.capture = (stateQ == ST_READ) && memAck;
    strb.merge   = (stateQ == ST_CHECK) && entryPresent;
    strb.advance = ((stateQ == ST_CHECK) && entryPresent && entryAccessed)
                 || ((stateQ == ST_WRITE_A) && memAck);
  end

  assign memReq    = (stateQ == ST_READ) || (stateQ == ST_WRITE_A);
  assign memWe     = (stateQ == ST_WRITE_A);
  assign busy      = (stateQ != ST_IDLE);
  assign doneValid = (stateQ == ST_DONE) || (stateQ == ST_FAULT);
  assign doneFault = (stateQ == ST_FAULT);
endmodule

// File: rtl/walk_datapath.sv
module walk_datapath
  import walk_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int PPN_W  = 40,
  parameter int OFF_W  = 12,
  localparam int VPN_W  = LEVELS * IDX_W,
  localparam int LVL_W  = $clog2(LEVELS),
  localparam int FLV_W  = $clog2(LEVELS + 1),
  localparam int ADDR_W = PPN_W + IDX_W + 3,
  localparam int PA_W   = PPN_W + OFF_W
)(
  input  logic               clk,
  input  logic               rstN,
  input  walkStrobe_t        strb,
  input  logic [PPN_W-1:0]   rootBase,
  input  logic [VPN_W-1:0]   reqVpn,
  input  logic [OFF_W-1:0]   reqOffset,
  input  logic [ENTRY_W-1:0] memRdata,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [ENTRY_W-1:0] memWdata,
  output logic               entryPresent,
  output logic               entryAccessed,
  output logic               lastLevel,
  output logic [FLV_W-1:0]   faultLevel,
  output logic [PPN_W-1:0]   ppn,
  output logic [PA_W-1:0]    physAddr,
  output logic               permWrite,
  output logic               permUser,
  output logic               execDisable,
  output logic               globalPage
);
  logic [VPN_W-1:0]   vpnQ;
  logic [OFF_W-1:0]   offQ;
  logic [PPN_W-1:0]   baseQ;
  logic [LVL_W-1:0]   levelQ;
  logic [ENTRY_W-1:0] entryQ;
  logic               wrQ, usrQ, xdQ, glbQ;
  logic [IDX_W-1:0]   idxSel;

  always_comb begin
    idxSel = '0;
    for (int k = 0; k < LEVELS; k++) begin
      if (levelQ == LVL_W'(k)) idxSel = vpnQ[VPN_W-1-k*IDX_W -: IDX_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vpnQ <= '0; offQ <= '0; baseQ <= '0; levelQ <= '0; entryQ <= '0;
      wrQ <= 1'b0; usrQ <= 1'b0; xdQ <= 1'b0; glbQ <= 1'b0;
    end else begin
      if (strb.load) begin
        vpnQ   <= reqVpn;
        offQ   <= reqOffset;
        baseQ  <= rootBase;
        levelQ <= '0;
        wrQ    <= 1'b1;
        usrQ   <= 1'b1;
        xdQ    <= 1'b0;
        glbQ   <= 1'b0;
      end
      if (strb.capture) entryQ <= memRdata;
      if (strb.merge) begin
        wrQ  <= wrQ  & entryQ[BIT_WRITE];
        usrQ <= usrQ & entryQ[BIT_USER];
        xdQ  <= xdQ  | entryQ[BIT_NOEXEC];
        glbQ <= entryQ[BIT_GLOBAL];
      end
      if (strb.advance) begin
        baseQ <= entryQ[OFF_W+PPN_W-1:OFF_W];
        if (!lastLevel) levelQ <= levelQ + 1'b1;
      end
    end
  end

  assign memAddr       = {baseQ, idxSel, 3'b000};
  assign memWdata      = entryQ | (ENTRY_W'(1) << BIT_ACCESS);
  assign entryPresent  = entryQ[BIT_PRESENT];
  assign entryAccessed = entryQ[BIT_ACCESS];
  assign lastLevel     = (levelQ == LVL_W'(LEVELS - 1));
  assign faultLevel    = FLV_W'(levelQ) + 1'b1;
  assign ppn           = baseQ;
  assign physAddr      = {baseQ, offQ};
  assign permWrite     = wrQ;
  assign permUser      = usrQ;
  assign execDisable   = xdQ;
  assign globalPage    = glbQ;
endmodule

// File: rtl/table_walker.sv
module table_walker
  import walk_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int PPN_W  = 40,
  parameter int OFF_W  = 12,
  localparam int VPN_W  = LEVELS * IDX_W,
  localparam int FLV_W  = $clog2(LEVELS + 1),
  localparam int ADDR_W = PPN_W + IDX_W + 3,
  localparam int PA_W   = PPN_W + OFF_W
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               startValid,
  input  logic [VPN_W-1:0]   reqVpn,
  input  logic [OFF_W-1:0]   reqOffset,
  input  logic [PPN_W-1:0]   rootBase,
  output logic               busy,
  output logic               memReq,
  output logic               memWe,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [ENTRY_W-1:0] memWdata,
  input  logic               memAck,
  input  logic [ENTRY_W-1:0] memRdata,
  output logic               doneValid,
  output logic               doneFault,
  output logic [FLV_W-1:0]   faultLevel,
  output logic [PPN_W-1:0]   ppn,
  output logic [PA_W-1:0]    physAddr,
  output logic               permWrite,
  output logic               permUser,
  output logic               execDisable,
  output logic               globalPage
);
  walkStrobe_t strb;
  logic entryPresent, entryAccessed, lastLevel;

  walk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .memAck(memAck),
    .entryPresent(entryPresent), .entryAccessed(entryAccessed),
    .lastLevel(lastLevel), .strb(strb), .memReq(memReq), .memWe(memWe),
    .busy(busy), .doneValid(doneValid), .doneFault(doneFault)
  );

  walk_datapath #(.LEVELS(LEVELS), .IDX_W(IDX_W), .PPN_W(PPN_W), .OFF_W(OFF_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rootBase(rootBase),
    .reqVpn(reqVpn), .reqOffset(reqOffset), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .entryPresent(entryPresent),
    .entryAccessed(entryAccessed), .lastLevel(lastLevel),
    .faultLevel(faultLevel), .ppn(ppn), .physAddr(physAddr),
    .permWrite(permWrite), .permUser(permUser),
    .execDisable(execDisable), .globalPage(globalPage)
  );
endmodule

// File: rtl/walk_checker.sv
module walk_checker #(
  parameter int LEVELS = 4,
  parameter int ADDR_W = 52,
  parameter int FLV_W  = 3
)(
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [63:0]       memWdata,
  input logic              memAck,
  input logic              doneValid,
  input logic              doneFault,
  input logic [FLV_W-1:0]  faultLevel
);
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata));

  // R5
  wb_sets_acc_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe |-> memWdata[5]);

  // R4
  fault_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneFault |-> doneValid && !memReq && faultLevel >= 1 && faultLevel <= FLV_W'(LEVELS));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid && !busy);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq && !doneValid);
endmodule

bind table_walker walk_checker #(.LEVELS(LEVELS), .ADDR_W(ADDR_W), .FLV_W(FLV_W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .memReq(memReq), .memWe(memWe),
  .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck),
  .doneValid(doneValid), .doneFault(doneFault), .faultLevel(faultLevel)
);

// File: tb/sim_table_walker.sv
module sim_table_walker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic [35:0] reqVpn = '0;
  logic [11:0] reqOffset = '0;
  logic [39:0] rootBase = '0;
  logic        busy, memReq, memWe, memAck = 1'b0;
  logic [51:0] memAddr;
  logic [63:0] memWdata, memRdata = '0;
  logic        doneValid, doneFault, permWrite, permUser, execDisable, globalPage;
  logic [2:0]  faultLevel;
  logic [39:0] ppn;
  logic [51:0] physAddr;

  always #10 clk = ~clk;

  table_walker u0 (
    .clk(clk), .rstN(rstN), .startValid(startValid), .reqVpn(reqVpn),
    .reqOffset(reqOffset), .rootBase(rootBase), .busy(busy), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck),
    .memRdata(memRdata), .doneValid(doneValid), .doneFault(doneFault),
    .faultLevel(faultLevel), .ppn(ppn), .physAddr(physAddr),
    .permWrite(permWrite), .permUser(permUser), .execDisable(execDisable),
    .globalPage(globalPage)
  );

  localparam logic [63:0] FP = 64'h1, FW = 64'h2, FU = 64'h4, FA = 64'h20,
                          FG = 64'h100, FX = 64'h8000_0000_0000_0000;

  typedef struct {
    logic        fault;
    logic [2:0]  level;
    logic [39:0] ppn;
    logic [51:0] pa;
    logic        w, u, xd, g;
    int          writes;
    string       tag;
  } expect_t;

  expect_t     sbQ[$];
  logic [63:0] mem [logic [51:0]];
  int errors = 0, checks = 0, doneCount = 0, writeCount = 0, latency = 0, latCnt = 0;
  int cycles = 0;
  logic prevDone = 1'b0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory model: answers at negedge after the chosen latency
  always @(negedge clk) begin
    if (memReq && !memAck) begin
      if (latCnt >= latency) begin
        memAck = 1'b1;
        latCnt = 0;
        if (memWe) begin
          mem[memAddr] = memWdata;
          writeCount++;
        end else begin
          memRdata = mem.exists(memAddr) ? mem[memAddr] : 64'h0;
        end
      end else latCnt++;
    end else memAck = 1'b0;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (prevDone && doneValid) chk("R8", "double pulse", 1, 0);
      if (doneValid) begin
        expect_t e;
        if (sbQ.size() == 0) chk("R8", "unexpected result", 1, 0);
        else begin
          e = sbQ.pop_front();
          chk("R4", {e.tag, " fault"}, doneFault, e.fault);
          chk("R5", {e.tag, " writes"}, writeCount, e.writes);
          if (e.fault) chk("R4", {e.tag, " level"}, faultLevel, e.level);
          else begin
            chk("R7", {e.tag, " ppn"}, ppn, e.ppn);
            chk("R7", {e.tag, " pa"}, physAddr, e.pa);
            chk("R7", {e.tag, " global"}, globalPage, e.g);
            chk("R6", {e.tag, " w"}, permWrite, e.w);
            chk("R6", {e.tag, " u"}, permUser, e.u);
            chk("R6", {e.tag, " xd"}, execDisable, e.xd);
          end
        end
        writeCount = 0;
        doneCount++;
      end
    end
    prevDone = doneValid;
  end

  // watchdog
  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic runWalk(input string tag, input logic [39:0] b0, b1, b2, b3, fin,
                         input logic [35:0] vpn, input logic [11:0] off,
                         input logic [63:0] f0, f1, f2, f3, input int lat, input bit poke);
    logic [39:0] bs[5];
    logic [63:0] fl[4];
    logic [51:0] ad[4];
    logic [63:0] ent[4];
    expect_t e;
    int startDone, stop;
    bs[0] = b0; bs[1] = b1; bs[2] = b2; bs[3] = b3; bs[4] = fin;
    fl[0] = f0; fl[1] = f1; fl[2] = f2; fl[3] = f3;
    mem.delete();
    e.fault = 0; e.level = 0; e.w = 1; e.u = 1; e.xd = 0; e.g = 0; e.writes = 0; e.tag = tag;
    stop = 4;
    for (int k = 0; k < 4; k++) begin
      ad[k]  = {bs[k], vpn[35-9*k -: 9], 3'b000};
      ent[k] = (fl[k] & ~64'h000F_FFFF_FFFF_F000) | ({24'b0, bs[k+1]} << 12);
      mem[ad[k]] = ent[k];
    end
    for (int k = 3; k >= 0; k--) if (!fl[k][0]) stop = k;
    if (stop < 4) begin e.fault = 1; e.level = 3'(stop + 1); end
    for (int k = 0; k < stop; k++) begin
      if (!fl[k][5]) e.writes++;
      e.w &= fl[k][1]; e.u &= fl[k][2]; e.xd |= fl[k][63];
    end
    e.g = fl[3][8]; e.ppn = fin; e.pa = {fin, off};
    sbQ.push_back(e);
    latency = lat; startDone = doneCount;
    rootBase = b0; reqVpn = vpn; reqOffset = off; startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    if (poke) begin
      reqVpn = ~vpn; reqOffset = ~off; rootBase = ~b0; startValid = 1'b1;
      repeat (3) @(negedge clk);
      startValid = 1'b0;
    end
    for (int i = 0; i < 3000 && doneCount == startDone; i++) @(negedge clk);
    chk("R8", {tag, " completed"}, doneCount - startDone, 1);
    // R5: visited present entries now carry the accessed flag; fault entry untouched
    for (int k = 0; k < stop; k++) chk("R5", {tag, " acc bit"}, mem[ad[k]], ent[k] | FA);
    if (stop < 4) chk("R4", {tag, " fault entry kept"}, mem[ad[stop]], ent[stop]);
    if (poke) begin
      repeat (10) @(negedge clk);
      chk("R8", {tag, " start ignored while busy"}, doneCount - startDone, 1);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "busy", busy, 0);
    chk("R1", "memReq", memReq, 0);
    chk("R1", "doneValid", doneValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "idle after release", busy, 0);

    // R2 R5 R7: all present, accessed clear, distinct indices
    runWalk("allclear", 40'h00001, 40'h00002, 40'h00003, 40'h00004, 40'hABCDE,
            {9'h1A5, 9'h0F3, 9'h002, 9'h1FF}, 12'h7C4,
            FP|FW|FU, FP|FW|FU, FP|FW|FU, FP|FW|FU|FG, 0, 0);
    // R5: accessed already set, no writes, slow memory
    runWalk("allset", 40'h12345, 40'h0BEEF, 40'h00777, 40'hF0F0F, 40'h55555,
            {9'h000, 9'h001, 9'h100, 9'h0AA}, 12'h001,
            FP|FW|FU|FA, FP|FW|FU|FA, FP|FW|FU|FA, FP|FW|FU|FA, 2, 0);
    // R6: permissions merge across levels
    runWalk("perm", 40'h00100, 40'h00200, 40'h00300, 40'h00400, 40'h00ABC,
            {9'h011, 9'h022, 9'h033, 9'h044}, 12'hFFF,
            FP|FW|FU, FP|FU|FX, FP|FW|FA, FP|FW|FU|FA, 1, 0);
    // R6: execute-disable only at the last level
    runWalk("xdlast", 40'h00500, 40'h00600, 40'h00700, 40'h00800, 40'hFFFFF,
            {9'h1FF, 9'h1FF, 9'h1FF, 9'h1FF}, 12'h000,
            FP|FW|FU|FA, FP|FW|FU, FP|FW|FU|FA, FP|FW|FU|FX|FG, 0, 0);
    // R4: fault at level 1, other flag bits set
    runWalk("fault1", 40'h00900, 40'h00A00, 40'h00B00, 40'h00C00, 40'h01111,
            {9'h005, 9'h006, 9'h007, 9'h008}, 12'h123,
            FW|FU|FA|FG, FP, FP, FP, 0, 0);
    // R4: fault at level 3, one write before it
    runWalk("fault3", 40'h00D00, 40'h00E00, 40'h00F00, 40'h01000, 40'h02222,
            {9'h010, 9'h020, 9'h040, 9'h080}, 12'h456,
            FP, FP|FA, FW|FA, FP, 1, 0);
    // R4: fault at level 4
    runWalk("fault4", 40'h02000, 40'h03000, 40'h04000, 40'h05000, 40'h03333,
            {9'h0FF, 9'h100, 9'h101, 9'h102}, 12'h789,
            FP, FP, FP, FW|FU, 2, 0);
    // R8: start raised with other inputs while busy
    runWalk("overlap", 40'h06000, 40'h07000, 40'h08000, 40'h09000, 40'h4ABCD,
            {9'h0C3, 9'h13C, 9'h055, 9'h1AA}, 12'h5A5,
            FP|FW|FU, FP|FW|FU, FP|FW|FU, FP|FW|FU, 2, 1);

    chk("R8", "scoreboard empty", sbQ.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule